// File: doc/BRIEF.md
# Gated Fractional Clock Divider Bank

This block holds four independent rate channels behind one 32-bit control word. Each channel turns a reference clock into a stream of phase steps whose long-run rate is 18/frac of the reference, where frac is a 6-bit fraction held in the channel's own byte. Each reference cycle, the step stream of a channel is a 2-bit count of 0, 1 or 2 steps, so a downstream phase stepper or clock-enable generator can consume it directly.

Software stops a channel by setting its gate bit. It may reprogram the fraction only while the channel is stopped, and then releases the gate. A read-only ready flag in the same byte reports when the output has had a fixed number of reference cycles to settle after the release. All four bytes are written in one bus cycle, with a byte enable for each channel, and the whole word can be read back at any time.

Top module: `frac_div_bank`

## Requirements
- R1: After reset every channel byte reads 0x92: gate (bit 7) = 1, ready (bit 6) = 0, fraction (bits [5:0]) = 18, so the word reads 0x92929292 and all step counts are 0.
- R2: Channel n is controlled and observed only through byte n of the word (bits [8n+7:8n]). A write with wr_be[n] = 0 leaves channel n unchanged.
- R3: While a channel's registered gate bit is 1, the step count it outputs is 0 from the cycle after the gate was set.
- R4: A written fraction is stored only if the channel's gate bit was 1 before that write. While the channel runs, its fraction stays unchanged.
- R5: A written fraction of 0 is stored as 0. Values 1 to 11 are stored as 12, values 36 to 63 as 35, and values 12 to 35 unchanged.
- R6: A running channel whose fraction is 0 outputs a step count of 0 on every cycle.
- R7: On each clock edge after the ungating edge, a running channel adds 18 to a residue. It outputs on step[2n+1:2n] the number of times (0, 1 or 2) its fraction can be subtracted, and keeps what remains. Over N cycles the steps total floor(18N/frac).
- R8: The ready bit reads 0 while gated and for SETTLE-1 cycles after the ungating edge, and reads 1 from SETTLE edges after that edge (SETTLE defaults to 16). It reads 0 again from the edge on which the gate is set.
- R9: Bit 6 of every byte is read-only, and the value written to it has no effect.
- R10: The residue restarts at zero on every ungate, so the step sequence after an ungate does not depend on earlier runs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_be | input | 4 | Byte enable, one bit for each channel |
| wr_data | input | 32 | Write data, one byte for each channel |
| rd_data | output | 32 | Current control and status word |
| step | output | 8 | Registered step count, 2 bits for each channel |

## Verification
The bench concentrates on the fraction being clamped and frozen. A fraction write while a channel runs must be ignored, and a design that accepted it would change the rate mid-stream. It checks long-run step totals at both ends of the range, 12 and 35, where a wrong subtract or a missing double step shows up as a total that is off. It checks the exact cycle on which ready rises and falls, since an off-by-one counter or a ready flag that lingers after gating gives the wrong bit in a single readback. A channel left with a fraction of 0 must stay silent. A re-ungated channel must replay the step sequence 1, 2, 1 for fraction 12, which fails if the residue is not cleared.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef struct packed {
    logic       gate;
    logic       ready;
    logic [5:0] frac;
  } chan_byte_t;
endpackage

// File: rtl/fdiv_rst_sync.sv
module fdiv_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/fdiv_chan_ctrl.sv
module fdiv_chan_ctrl #(
  parameter int unsigned FRAC_W   = 6,
  parameter int unsigned FRAC_MIN = 12,
  parameter int unsigned FRAC_MAX = 35,
  parameter int unsigned FRAC_RST = 18,
  parameter int unsigned SETTLE   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_gate,
  input  logic [FRAC_W-1:0] wr_frac,
  output logic              gate_o,
  output logic              ready_o,
  output logic [FRAC_W-1:0] frac_o
);
  localparam int unsigned CNT_W = $clog2(SETTLE + 1);
  localparam logic [CNT_W-1:0] CNT_DONE = CNT_W'(SETTLE);

  logic              gate_q, gate_d;
  logic [FRAC_W-1:0] frac_q, frac_d, frac_clamped;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  always_comb begin
    if (wr_frac == '0)                      frac_clamped = '0;
    else if (wr_frac < FRAC_W'(FRAC_MIN))   frac_clamped = FRAC_W'(FRAC_MIN);
    else if (wr_frac > FRAC_W'(FRAC_MAX))   frac_clamped = FRAC_W'(FRAC_MAX);
    else                                    frac_clamped = wr_frac;
  end

  always_comb begin
    gate_d = gate_q;
    frac_d = frac_q;
    if (wr_en) begin
      gate_d = wr_gate;
      if (gate_q) frac_d = frac_clamped;
    end
  end

  always_comb begin
    if (gate_q || gate_d)      cnt_d = '0;
    else if (cnt_q != CNT_DONE) cnt_d = cnt_q + 1'b1;
    else                        cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b1;
      frac_q <= FRAC_W'(FRAC_RST);
      cnt_q  <= '0;
    end else begin
      gate_q <= gate_d;
      frac_q <= frac_d;
      cnt_q  <= cnt_d;
    end
  end

  assign gate_o  = gate_q;
  assign frac_o  = frac_q;
  assign ready_o = (cnt_q == CNT_DONE);

  AST_FRAC_FROZEN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_q |=> $stable(frac_q)); // R4
  AST_FRAC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (frac_q == '0) || ((frac_q >= FRAC_W'(FRAC_MIN)) && (frac_q <= FRAC_W'(FRAC_MAX)))); // R5
  AST_READY_LOW_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    gate_q |-> !ready_o); // R8
  AST_READY_RISE_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> !gate_q); // R8
endmodule

// File: rtl/fdiv_phase_acc.sv
module fdiv_phase_acc #(
  parameter int unsigned FRAC_W = 6,
  parameter int unsigned NUMER  = 18,
  parameter int unsigned STEP_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gate,
  input  logic [FRAC_W-1:0] frac,
  output logic [STEP_W-1:0] step_o
);
  localparam int unsigned SUM_W = FRAC_W + 2;

  logic [FRAC_W-1:0] acc_q, acc_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic [SUM_W-1:0]  sum, one_f, two_f, rem;

  assign sum   = SUM_W'(acc_q) + SUM_W'(NUMER);
  assign one_f = SUM_W'(frac);
  assign two_f = SUM_W'(frac) << 1;

  always_comb begin
    rem    = sum;
    step_d = '0;
    if (sum >= two_f) begin
      rem    = sum - two_f;
      step_d = STEP_W'(2);
    end else if (sum >= one_f) begin
      rem    = sum - one_f;
      step_d = STEP_W'(1);
    end
    acc_d = rem[FRAC_W-1:0];
    if (gate || (frac == '0)) begin
      acc_d  = '0;
      step_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      step_q <= '0;
    end else begin
      acc_q  <= acc_d;
      step_q <= step_d;
    end
  end

  assign step_o = step_q;

  AST_NO_STEP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (gate || (frac == '0)) |=> (step_q == '0)); // R3
  AST_STEP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    step_q <= STEP_W'(2)); // R7
  AST_RESIDUE_BELOW_FRAC: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate && (frac != '0)) |-> (acc_q < frac)); // R7
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate) |-> (acc_q == '0)); // R10
endmodule

// File: rtl/frac_div_bank.sv
module frac_div_bank #(
  parameter int unsigned NUM_CH   = 4,
  parameter int unsigned NUMER    = 18,
  parameter int unsigned FRAC_MIN = 12,
  parameter int unsigned FRAC_MAX = 35,
  parameter int unsigned FRAC_RST = 18,
  parameter int unsigned SETTLE   = 16,
  parameter int unsigned STEP_W   = 2
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 wr_en,
  input  logic [NUM_CH-1:0]                    wr_be,
  input  logic [NUM_CH*fdiv_pkg::BYTE_W-1:0]   wr_data,
  output logic [NUM_CH*fdiv_pkg::BYTE_W-1:0]   rd_data,
  output logic [NUM_CH*STEP_W-1:0]             step
);
  import fdiv_pkg::*;
  localparam int unsigned FRAC_W = 6;

  logic rst_sync_n;
  logic [NUM_CH-1:0] unused_ready_bits;

  fdiv_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar n = 0; n < NUM_CH; n++) begin : g_chan
    chan_byte_t        wr_b, rd_b;
    logic              gate, ready;
    logic [FRAC_W-1:0] frac;

    assign wr_b = wr_data[n*BYTE_W +: BYTE_W];
    assign unused_ready_bits[n] = wr_b.ready;

    fdiv_chan_ctrl #(
      .FRAC_W   (FRAC_W),
      .FRAC_MIN (FRAC_MIN),
      .FRAC_MAX (FRAC_MAX),
      .FRAC_RST (FRAC_RST),
      .SETTLE   (SETTLE)
    ) i_ctrl (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .wr_en   (wr_en && wr_be[n]),
      .wr_gate (wr_b.gate),
      .wr_frac (wr_b.frac),
      .gate_o  (gate),
      .ready_o (ready),
      .frac_o  (frac)
    );

    fdiv_phase_acc #(
      .FRAC_W (FRAC_W),
      .NUMER  (NUMER),
      .STEP_W (STEP_W)
    ) i_acc (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .gate   (gate),
      .frac   (frac),
      .step_o (step[n*STEP_W +: STEP_W])
    );

    assign rd_b.gate  = gate;
    assign rd_b.ready = ready;
    assign rd_b.frac  = frac;
    assign rd_data[n*BYTE_W +: BYTE_W] = rd_b;
  end
endmodule

// File: tb/test_frac_div_bank.sv
module test_frac_div_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int SETTLE = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_be = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [7:0]  step;

  int checks = 0;
  int errors = 0;
  int m_gate[NCH], m_frac[NCH], m_acc[NCH], m_cnt[NCH], m_step[NCH];

  frac_div_bank i_frac_div_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be),
    .wr_data(wr_data), .rd_data(rd_data), .step(step)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int clampf(input int v);
    if (v == 0) return 0;
    if (v < 12) return 12;
    if (v > 35) return 35;
    return v;
  endfunction

  task automatic model_edge();
    for (int c = 0; c < NCH; c++) begin
      int g, f, ng, nf, s;
      g = m_gate[c]; f = m_frac[c]; ng = g; nf = f;
      if (wr_en && wr_be[c]) begin
        ng = wr_data[8*c+7];
        if (g != 0) nf = clampf(int'(wr_data[8*c +: 6]));
      end
      if (g != 0 || f == 0) begin
        m_acc[c] = 0; m_step[c] = 0;
      end else begin
        s = m_acc[c] + 18;
        if (s >= 2*f)      begin m_step[c] = 2; m_acc[c] = s - 2*f; end
        else if (s >= f)   begin m_step[c] = 1; m_acc[c] = s - f; end
        else               begin m_step[c] = 0; m_acc[c] = s; end
      end
      if (g != 0 || ng != 0) m_cnt[c] = 0;
      else if (m_cnt[c] < SETTLE) m_cnt[c]++;
      m_gate[c] = ng; m_frac[c] = nf;
    end
  endtask

  task automatic compare_all();
    logic [31:0] exp_rd;
    logic [7:0]  exp_st;
    for (int c = 0; c < NCH; c++) begin
      exp_rd[8*c +: 8] = {m_gate[c][0], (m_cnt[c] == SETTLE), m_frac[c][5:0]};
      exp_st[2*c +: 2] = m_step[c][1:0];
    end
    chk(rd_data === exp_rd, "R2 model word", rd_data, exp_rd);
    chk(step === exp_st, "R7 model steps", {24'h0, step}, {24'h0, exp_st});
  endtask

  task automatic cycle();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
  endtask

  task automatic wr(input logic [3:0] be, input logic [31:0] d);
    wr_en = 1'b1; wr_be = be; wr_data = d;
    cycle();
    wr_en = 1'b0; wr_be = '0; wr_data = '0;
  endtask

  initial begin
    int sum0, sum1, sum3;
    for (int c = 0; c < NCH; c++) begin
      m_gate[c] = 1; m_frac[c] = 18; m_acc[c] = 0; m_cnt[c] = 0; m_step[c] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) cycle();
    chk(rd_data === 32'h92929292, "R1 reset word", rd_data, 32'h92929292);
    chk(step === 8'h00, "R1 reset steps", {24'h0, step}, 32'h0);

    // R5 clamp, R9 bit 6 ignored: ch3 0xFF->0xA3, ch2 0x85->0x8C
    wr(4'hF, 32'hFF85A38C);
    chk(rd_data === 32'hA38CA38C, "R5 R9 clamp and ready bit", rd_data, 32'hA38CA38C);

    // R2 byte enable only touches ch2
    wr(4'b0100, 32'h8C948C8C);
    chk(rd_data === 32'hA394A38C, "R2 byte enable", rd_data, 32'hA394A38C);

    // ungate ch0 (frac 12) and ch1 (frac 35)
    wr(4'b0011, 32'h0000230C);
    sum0 = 0; sum1 = 0;
    for (int i = 1; i <= 180; i++) begin
      cycle();
      sum0 += int'(step[1:0]);
      sum1 += int'(step[3:2]);
      if (i == SETTLE - 1 || i == SETTLE)
        chk(rd_data[6] === (i >= SETTLE), "R8 ready timing", {31'h0, rd_data[6]}, {31'h0, (i >= SETTLE)});
    end
    chk(sum0 == 270, "R7 total frac 12", sum0, 270);
    chk(sum1 == 92, "R7 total frac 35", sum1, 92);

    // R4 fraction write while running ignored
    wr(4'b0001, 32'h00000014);
    chk(rd_data[7:0] === 8'h4C, "R4 frozen fraction", {24'h0, rd_data[7:0]}, 32'h4C);

    // R6 zero fraction silent
    wr(4'b1000, 32'h80000000);
    chk(rd_data[31:24] === 8'h80, "R5 zero stored", {24'h0, rd_data[31:24]}, 32'h80);
    wr(4'b1000, 32'h00000000);
    sum3 = 0;
    for (int i = 0; i < 40; i++) begin
      cycle();
      sum3 += int'(step[7:6]);
    end
    chk(sum3 == 0, "R6 zero fraction no steps", sum3, 0);

    // R3 R8 gating
    wr(4'b0001, 32'h0000008C);
    chk(rd_data[7:0] === 8'h8C, "R8 ready clears on gate", {24'h0, rd_data[7:0]}, 32'h8C);
    cycle();
    chk(step[1:0] === 2'd0, "R3 gated no steps", {30'h0, step[1:0]}, 32'h0);
    repeat (5) cycle();
    chk(step[1:0] === 2'd0, "R3 still gated", {30'h0, step[1:0]}, 32'h0);

    // R10 restart sequence 1,2,1 for frac 12
    wr(4'b0001, 32'h0000000C);
    cycle(); chk(step[1:0] === 2'd1, "R10 restart step 1", {30'h0, step[1:0]}, 32'd1);
    cycle(); chk(step[1:0] === 2'd2, "R10 restart step 2", {30'h0, step[1:0]}, 32'd2);
    cycle(); chk(step[1:0] === 2'd1, "R10 restart step 3", {30'h0, step[1:0]}, 32'd1);
    chk(step[5:4] === 2'd0, "R3 ch2 stays gated", {30'h0, step[5:4]}, 32'h0);

    summary();
    $finish;
  end
endmodule